// File: doc/BRIEF.md
# VMID-tagged guest translation cache

This block is a small, fully associative cache of address translations for a core that runs virtual machines. Each entry has one of two kinds. A guest-physical entry maps a guest physical page to a supervisor physical page. A combined entry maps a guest virtual page directly to a supervisor physical page. Every entry is tagged with the VMID of the guest that owns it. Pages are 4 KiB.

The core uses three ports:

- **Lookup port.** Presents a kind, a VMID and a page tag. The hit flag and the physical page number come back one cycle later.
- **Refill port.** Installs a new translation from the page-table walker.
- **Fence port.** Removes stale translations in a single cycle when the hypervisor changes second-stage mappings. It carries a guest physical address operand that arrives shifted right by two bits, a VMID operand, and one flag for each operand that says whether it is present.
  - A guest-physical entry is dropped only when it matches both the address selection and the VMID selection.
  - A combined entry cannot be traced back to the guest physical page that built it. It is therefore dropped whenever its VMID is selected, whatever the address operand says.

Top module: `gtlb_cache`

## Requirements
- R1: After reset every entry is invalid, `lk_hit` is 0 and `lk_ppn` is 0, and lookups miss until a refill.
- R2: A lookup hits only on a valid entry whose kind, VMID and tag all equal the request. The kind encoding is 0 for guest-physical and 1 for combined. `lk_hit` and `lk_ppn` are registered and appear one cycle after the request. On a miss, or when no request is made, both outputs are 0.
- R3: A refill writes the lowest-numbered invalid entry. When every entry is valid, it writes the entry chosen by a replacement pointer. The pointer is 0 after reset, advances by one on each such replacement only, and wraps after the last entry.
- R4: The fence address operand is a guest physical address shifted right by 2. Its bits [TAG_W+9:10] form the page tag. A guest-physical entry is invalidated when that tag equals the entry's tag and the entry passes the VMID selection. A guest-physical entry with a different tag is kept.
- R5: A combined entry is invalidated when it passes the VMID selection, whatever the address operand holds.
- R6: With `fn_has_vmid` at 1, only entries whose VMID equals `fn_vmid` are eligible, and entries of other VMIDs are kept. With `fn_has_vmid` at 0, entries of every VMID are eligible.
- R7: With `fn_has_addr` at 0, every guest-physical entry that passes the VMID selection is invalidated.
- R8: When a fence and a refill occur in the same cycle, the fence acts first. The refilled entry survives the fence, and the refill may use an entry that the fence freed.
- R9: A lookup in the same cycle as a fence or a refill sees the contents from before that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_req | input | 1 | Lookup request |
| lk_kind | input | 1 | Lookup kind: 0 guest-physical, 1 combined |
| lk_vmid | input | VMID_W | Lookup VMID |
| lk_tag | input | TAG_W | Lookup page tag |
| lk_hit | output | 1 | Registered hit flag |
| lk_ppn | output | PPN_W | Registered physical page number, 0 on miss |
| rf_en | input | 1 | Refill strobe |
| rf_kind | input | 1 | Refill kind |
| rf_vmid | input | VMID_W | Refill VMID |
| rf_tag | input | TAG_W | Refill page tag |
| rf_ppn | input | PPN_W | Refill physical page number |
| fn_en | input | 1 | Fence strobe |
| fn_has_addr | input | 1 | Address operand present |
| fn_has_vmid | input | 1 | VMID operand present |
| fn_addr | input | TAG_W+10 | Guest physical address shifted right by 2 |
| fn_vmid | input | VMID_W | Fence VMID operand |

## Verification
A refill or fence changes the array at the edge where it is presented, so only a lookup in a later cycle sees the change. A lookup result becomes visible one edge after its request. Each bench step drives its refill, fence and lookup together on a falling edge and checks `lk_hit` and `lk_ppn` on the next falling edge. The expected value is therefore always the contents from before that step. Replacement order is checked by filling all entries, replacing some, and then probing which old tags still hit.

// File: rtl/gtlb_cache.sv
module gtlb_cache #(
  parameter int ENTRIES = 8,
  parameter int VMID_W  = 14,
  parameter int TAG_W   = 20,
  parameter int PPN_W   = 20,
  localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int FADDR_W = TAG_W + 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               lk_req,
  input  logic               lk_kind,
  input  logic [VMID_W-1:0]  lk_vmid,
  input  logic [TAG_W-1:0]   lk_tag,
  output logic               lk_hit,
  output logic [PPN_W-1:0]   lk_ppn,
  input  logic               rf_en,
  input  logic               rf_kind,
  input  logic [VMID_W-1:0]  rf_vmid,
  input  logic [TAG_W-1:0]   rf_tag,
  input  logic [PPN_W-1:0]   rf_ppn,
  input  logic               fn_en,
  input  logic               fn_has_addr,
  input  logic               fn_has_vmid,
  input  logic [FADDR_W-1:0] fn_addr,
  input  logic [VMID_W-1:0]  fn_vmid
);

  logic [ENTRIES-1:0] vld, knd, kill, hv, vld_post;
  logic [VMID_W-1:0]  vm_q  [ENTRIES];
  logic [TAG_W-1:0]   tag_q [ENTRIES];
  logic [PPN_W-1:0]   ppn_q [ENTRIES];
  logic [IDX_W-1:0]   rr, free_idx, victim;
  logic               has_free, hit_any;
  logic [PPN_W-1:0]   hit_ppn;
  logic [FADDR_W+1:0] fence_gpa;
  logic [TAG_W-1:0]   fence_tag;

  assign fence_gpa = {fn_addr, 2'b00};
  assign fence_tag = fence_gpa[TAG_W+11:12];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
    logic vm_sel, ad_sel;
    assign vm_sel  = !fn_has_vmid || (vm_q[i] == fn_vmid);
    assign ad_sel  = !fn_has_addr || (tag_q[i] == fence_tag);
    assign kill[i] = fn_en && vld[i] && vm_sel && (knd[i] || ad_sel);
    assign hv[i]   = vld[i] && (knd[i] == lk_kind) && (vm_q[i] == lk_vmid) && (tag_q[i] == lk_tag);
  end

  assign vld_post = vld & ~kill;

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--)
      if (!vld_post[i]) begin
        has_free = 1'b1;
        free_idx = IDX_W'(i);
      end
  end

  assign victim = has_free ? free_idx : rr;

  always_comb begin
    hit_any = 1'b0;
    hit_ppn = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (hv[i]) begin
        hit_any = 1'b1;
        hit_ppn = hit_ppn | ppn_q[i];
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld    <= '0;
      rr     <= '0;
      lk_hit <= 1'b0;
      lk_ppn <= '0;
    end else begin
      vld <= vld_post;
      if (rf_en) begin
        vld[victim] <= 1'b1;
        if (!has_free)
          rr <= (rr == IDX_W'(ENTRIES - 1)) ? '0 : rr + 1'b1;
      end
      lk_hit <= lk_req && hit_any;
      lk_ppn <= (lk_req && hit_any) ? hit_ppn : '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rf_en) begin
      knd[victim]   <= rf_kind;
      vm_q[victim]  <= rf_vmid;
      tag_q[victim] <= rf_tag;
      ppn_q[victim] <= rf_ppn;
    end
  end

endmodule

// File: rtl/gtlb_cache_chk.sv
module gtlb_cache_chk #(
  parameter int VMID_W = 14,
  parameter int TAG_W  = 20,
  parameter int PPN_W  = 20,
  localparam int FADDR_W = TAG_W + 10
) (
  input logic               clk,
  input logic               rst_n,
  input logic               lk_req,
  input logic               lk_kind,
  input logic [VMID_W-1:0]  lk_vmid,
  input logic [TAG_W-1:0]   lk_tag,
  input logic               lk_hit,
  input logic [PPN_W-1:0]   lk_ppn,
  input logic               rf_en,
  input logic               rf_kind,
  input logic [VMID_W-1:0]  rf_vmid,
  input logic [TAG_W-1:0]   rf_tag,
  input logic [PPN_W-1:0]   rf_ppn,
  input logic               fn_en,
  input logic               fn_has_addr,
  input logic               fn_has_vmid,
  input logic [FADDR_W-1:0] fn_addr,
  input logic [VMID_W-1:0]  fn_vmid
);

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!lk_hit && lk_ppn == '0));

  a_r8_refill_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && $past(rf_en) && lk_kind == $past(rf_kind) && lk_vmid == $past(rf_vmid)
     && lk_tag == $past(rf_tag))
    |=> (lk_hit && lk_ppn == $past(rf_ppn, 2)));

  a_r5_combined_by_vmid: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && lk_kind && $past(fn_en) && $past(fn_has_vmid) && !$past(rf_en)
     && lk_vmid == $past(fn_vmid))
    |=> !lk_hit);

  a_r4_gp_by_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && !lk_kind && $past(fn_en) && $past(fn_has_vmid) && $past(fn_has_addr)
     && !$past(rf_en) && lk_vmid == $past(fn_vmid) && lk_tag == $past(fn_addr[TAG_W+9:10]))
    |=> !lk_hit);

  a_r6_global_flush: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_req && $past(fn_en) && !$past(fn_has_vmid) && !$past(fn_has_addr) && !$past(rf_en))
    |=> !lk_hit);

endmodule

bind gtlb_cache gtlb_cache_chk #(.VMID_W(VMID_W), .TAG_W(TAG_W), .PPN_W(PPN_W)) u_chk (.*);

// File: tb/gtlb_cache_bench.sv
module gtlb_cache_bench;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic lk_req = 0, lk_kind = 0, lk_hit;
  logic [13:0] lk_vmid = 0;
  logic [19:0] lk_tag = 0, lk_ppn;
  logic rf_en = 0, rf_kind = 0;
  logic [13:0] rf_vmid = 0;
  logic [19:0] rf_tag = 0, rf_ppn = 0;
  logic fn_en = 0, fn_has_addr = 0, fn_has_vmid = 0;
  logic [29:0] fn_addr = 0;
  logic [13:0] fn_vmid = 0;

  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gtlb_cache u_gtlb_cache (.*);

  typedef struct packed {
    logic        rf_en;
    logic        rf_kind;
    logic [13:0] rf_vmid;
    logic [19:0] rf_tag;
    logic [19:0] rf_ppn;
    logic        fn_en;
    logic        fn_ha;
    logic        fn_hv;
    logic [29:0] fn_addr;
    logic [13:0] fn_vmid;
    logic        lk_kind;
    logic [13:0] lk_vmid;
    logic [19:0] lk_tag;
    logic        ex_hit;
    logic [19:0] ex_ppn;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 19;
  localparam vec_t VEC [NV] = '{
    // R9: refill and lookup of the same key together, the lookup misses
    '{1, 0, 14'd3, 20'h10, 20'hA10, 0, 0, 0, 30'h0, 14'd0, 0, 14'd3, 20'h10, 0, 20'h0, 8'd9},
    // R2
    '{1, 1, 14'd3, 20'h10, 20'hB10, 0, 0, 0, 30'h0, 14'd0, 0, 14'd3, 20'h10, 1, 20'hA10, 8'd2},
    '{1, 0, 14'd5, 20'h20, 20'hA20, 0, 0, 0, 30'h0, 14'd0, 1, 14'd3, 20'h10, 1, 20'hB10, 8'd2},
    '{1, 1, 14'd5, 20'h30, 20'hB30, 0, 0, 0, 30'h0, 14'd0, 0, 14'd5, 20'h10, 0, 20'h0, 8'd2},
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 1, 14'd3, 20'h11, 0, 20'h0, 8'd2},
    // R9: fence by address 0x20 and VMID 3, lookup sees the old contents
    '{0, 0, 14'd0, 20'h0, 20'h0, 1, 1, 1, 30'h8000, 14'd3, 0, 14'd3, 20'h10, 1, 20'hA10, 8'd9},
    // R5: combined entry of VMID 3 removed despite the tag mismatch
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 1, 14'd3, 20'h10, 0, 20'h0, 8'd5},
    // R4: guest-physical entry with a different tag kept
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 0, 14'd3, 20'h10, 1, 20'hA10, 8'd4},
    // R6: other VMID kept
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 0, 14'd5, 20'h20, 1, 20'hA20, 8'd6},
    '{0, 0, 14'd0, 20'h0, 20'h0, 1, 1, 1, 30'h8000, 14'd5, 1, 14'd5, 20'h30, 1, 20'hB30, 8'd9},
    // R4: matching tag and VMID removed
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 0, 14'd5, 20'h20, 0, 20'h0, 8'd4},
    // R5
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 1, 14'd5, 20'h30, 0, 20'h0, 8'd5},
    '{1, 0, 14'd7, 20'h40, 20'hA40, 0, 0, 0, 30'h0, 14'd0, 0, 14'd3, 20'h10, 1, 20'hA10, 8'd2},
    // R8: a VMID-only fence and a refill in the same cycle
    '{1, 1, 14'd7, 20'h50, 20'hB50, 1, 0, 1, 30'h0, 14'd7, 0, 14'd7, 20'h40, 1, 20'hA40, 8'd9},
    // R7: no address operand, every guest-physical entry of VMID 7 removed
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 0, 14'd7, 20'h40, 0, 20'h0, 8'd7},
    // R8: the refilled entry survives
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 1, 14'd7, 20'h50, 1, 20'hB50, 8'd8},
    '{0, 0, 14'd0, 20'h0, 20'h0, 1, 0, 0, 30'h0, 14'd0, 0, 14'd3, 20'h10, 1, 20'hA10, 8'd9},
    // R6: no VMID operand, all VMIDs eligible
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 0, 14'd3, 20'h10, 0, 20'h0, 8'd6},
    '{0, 0, 14'd0, 20'h0, 20'h0, 0, 0, 0, 30'h0, 14'd0, 1, 14'd7, 20'h50, 0, 20'h0, 8'd6}
  };

  task automatic chk(input int req, input logic h, input logic [19:0] p,
                     input logic eh, input logic [19:0] ep);
    checks++;
    if (h !== eh || p !== ep) begin
      failures++;
      $display("FAIL R%0d hit=%0b ppn=%h expected hit=%0b ppn=%h", req, h, p, eh, ep);
    end
  endtask

  task automatic idle;
    rf_en = 0; fn_en = 0; lk_req = 0;
  endtask

  task automatic refill(input logic [19:0] t, input logic [19:0] p);
    rf_en = 1; rf_kind = 0; rf_vmid = 14'd1; rf_tag = t; rf_ppn = p;
    @(negedge clk);
    idle();
  endtask

  task automatic probe(input int req, input logic [19:0] t, input logic eh, input logic [19:0] ep);
    lk_req = 1; lk_kind = 0; lk_vmid = 14'd1; lk_tag = t;
    @(negedge clk);
    chk(req, lk_hit, lk_ppn, eh, ep);
    idle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state of the outputs
    chk(1, lk_hit, lk_ppn, 1'b0, 20'h0);
    rst_n = 1;
    @(negedge clk);
    // R1: nothing is valid yet
    lk_req = 1; lk_kind = 0; lk_vmid = 14'd0; lk_tag = 20'h0;
    @(negedge clk);
    chk(1, lk_hit, lk_ppn, 1'b0, 20'h0);
    idle();
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      rf_en = VEC[i].rf_en; rf_kind = VEC[i].rf_kind; rf_vmid = VEC[i].rf_vmid;
      rf_tag = VEC[i].rf_tag; rf_ppn = VEC[i].rf_ppn;
      fn_en = VEC[i].fn_en; fn_has_addr = VEC[i].fn_ha; fn_has_vmid = VEC[i].fn_hv;
      fn_addr = VEC[i].fn_addr; fn_vmid = VEC[i].fn_vmid;
      lk_req = 1; lk_kind = VEC[i].lk_kind; lk_vmid = VEC[i].lk_vmid; lk_tag = VEC[i].lk_tag;
      @(negedge clk);
      chk(int'(VEC[i].req), lk_hit, lk_ppn, VEC[i].ex_hit, VEC[i].ex_ppn);
    end
    idle();
    @(negedge clk);
    // R2: no request gives a zero output
    chk(2, lk_hit, lk_ppn, 1'b0, 20'h0);

    // R3: fill all entries, then replace through the pointer
    for (int i = 0; i < 8; i++) refill(20'h100 + 20'(i), 20'h100 + 20'(i));
    refill(20'h200, 20'h200);
    probe(3, 20'h100, 1'b0, 20'h0);
    probe(3, 20'h101, 1'b1, 20'h101);
    probe(3, 20'h200, 1'b1, 20'h200);
    refill(20'h201, 20'h201);
    probe(3, 20'h101, 1'b0, 20'h0);
    probe(3, 20'h102, 1'b1, 20'h102);
    // R3: a freed entry is filled before the pointer is used
    fn_en = 1; fn_has_addr = 1; fn_has_vmid = 1; fn_addr = 30'h41400; fn_vmid = 14'd1;
    @(negedge clk);
    idle();
    refill(20'h300, 20'h300);
    refill(20'h301, 20'h301);
    probe(3, 20'h102, 1'b0, 20'h0);
    probe(3, 20'h103, 1'b1, 20'h103);
    probe(3, 20'h104, 1'b1, 20'h104);
    probe(3, 20'h300, 1'b1, 20'h300);
    probe(3, 20'h301, 1'b1, 20'h301);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule